// File: doc/BRIEF.md
# Single-Bit Memory Operation Unit

This unit executes single-bit operations on a nibble-wide data memory. An upstream decoder hands it one operation at a time over a valid/ready stream: an operation code, an addressing-mode selector, an immediate address and bit field, the current H and L register values and the current carry. The unit forms the nibble address and the bit index, reads the nibble, and then writes it back modified or only tests it.

It reports the result to the core through a done pulse. With it come a skip request for the sequencer that discards the next instruction, the resulting carry, and an illegal flag for operation and mode pairs the unit does not support. Every legal operation is read in its first cycle and finished in its second. Memory is a plain synchronous port whose read data arrives on the cycle after the read request.

The operation stream follows these rules. The unit takes an operation on a clock edge where `in_valid` and `in_ready` are both high. It lowers `in_ready` until the done pulse of that operation has passed. While `in_ready` is low, the producer holds its offer.

Top module: `bitop_unit`

## Requirements
- R1: Operation codes on `in_op` are 0 set, 1 clear, 2 skip-if-one, 3 skip-if-zero, 4 skip-if-one-and-clear, 5 carry AND, 6 carry OR, 7 carry XOR. An operation is accepted on an edge with `in_valid` and `in_ready` high. `in_ready` is high only while no operation is in progress, and it is high with `done` low after reset.
- R2: Mode 0 (direct) addresses the nibble at `in_imm`. Mode 1 (fixed high window) addresses 0xC0 plus `in_imm[5:0]`. Both take the bit index from `in_bit`.
- R3: Mode 2 (register-indexed) addresses {`in_imm[7:2]`, `in_l[3:2]`} and takes the bit index from `in_l[1:0]`, ignoring `in_bit`.
- R4: Mode 3 (H-paged) addresses {`in_h`, `in_imm[3:0]`} with the bit index from `in_bit`.
- R5: Set writes 1 and clear writes 0 to the indexed bit, and the other three bits of the nibble keep their value.
- R6: Skip-if-one raises `skip` with `done` when the indexed bit is 1. Skip-if-zero raises it when the bit is 0. Neither writes memory.
- R7: Skip-if-one-and-clear raises `skip` and writes the nibble back with the indexed bit cleared when that bit is 1. When the bit is 0, it neither skips nor writes.
- R8: Carry AND, OR and XOR present `in_cy` combined with the indexed bit on `cy_out` during `done`, and leave memory untouched. Every other legal operation presents `in_cy` unchanged.
- R9: A legal operation drives `mem_rd_en` in the first cycle after acceptance and `done` in the second. Any write happens in the `done` cycle, at the address just read.
- R10: In mode 0, skip-if-one-and-clear and the three carry operations are illegal. Such an operation gives `done` and `illegal` in the first cycle after acceptance, with no memory read or write, `skip` low and `cy_out` equal to `in_cy`.
- R11: `done` lasts one cycle. `skip` and `illegal` are low outside `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation can be taken |
| in_op | input | 3 | Operation code |
| in_mode | input | 2 | Addressing mode |
| in_imm | input | 8 | Immediate address field |
| in_bit | input | 2 | Immediate bit index |
| in_h | input | 4 | H register value |
| in_l | input | 4 | L register value |
| in_cy | input | 1 | Carry before the operation |
| mem_addr | output | 8 | Nibble address |
| mem_rd_en | output | 1 | Read request, data due next cycle |
| mem_rdata | input | 4 | Read data |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| done | output | 1 | Operation finished, result pins valid |
| skip | output | 1 | Skip the following instruction |
| cy_out | output | 1 | Carry after the operation |
| illegal | output | 1 | Unsupported operation and mode pair |

## Verification
The assertions take it as given that the memory returns the nibble of the read address on the cycle after `mem_rd_en` and that nothing else writes that nibble between the read and the write-back. They also take it as given that an operation is offered only with its fields stable. The bench plays the memory itself with exactly that one-cycle read timing. It raises `in_valid` only while `in_ready` is high and drops it right after the accepting edge. It preloads nibbles only while the unit is idle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_SET    = 3'd0,
    OP_CLR    = 3'd1,
    OP_SKT    = 3'd2,
    OP_SKF    = 3'd3,
    OP_SKTCLR = 3'd4,
    OP_AND    = 3'd5,
    OP_OR     = 3'd6,
    OP_XOR    = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MD_DIRECT = 2'd0,
    MD_HIGHWIN = 2'd1,
    MD_REGIDX = 2'd2,
    MD_HPAGE  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_ILL  = 2'd3
  } state_e;
endpackage

// File: rtl/bitop_addr_gen.sv
module bitop_addr_gen
  import bitop_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NIB_W     = 4,
  parameter int WIN_OFS_W = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 8'hC0,
  localparam int BIT_W    = $clog2(NIB_W)
) (
  input  op_e               op,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] imm,
  input  logic [BIT_W-1:0]  bit_imm,
  input  logic [NIB_W-1:0]  h,
  input  logic [NIB_W-1:0]  l,
  output logic [ADDR_W-1:0] addr,
  output logic [BIT_W-1:0]  bsel,
  output logic              bad
);
  localparam int PAGE_LO_W = ADDR_W - NIB_W;

  always_comb begin
    addr = imm;
    bsel = bit_imm;
    unique case (mode)
      MD_DIRECT: begin
        addr = imm;
        bsel = bit_imm;
      end
      MD_HIGHWIN: begin
        addr = WIN_BASE | {{(ADDR_W-WIN_OFS_W){1'b0}}, imm[WIN_OFS_W-1:0]};
        bsel = bit_imm;
      end
      MD_REGIDX: begin
        addr = {imm[ADDR_W-1:BIT_W], l[2*BIT_W-1:BIT_W]};
        bsel = l[BIT_W-1:0];
      end
      MD_HPAGE: begin
        addr = {h, imm[PAGE_LO_W-1:0]};
        bsel = bit_imm;
      end
      default: ;
    endcase
  end

  always_comb begin
    bad = 1'b0;
    if (mode == MD_DIRECT) begin
      unique case (op)
        OP_SKTCLR, OP_AND, OP_OR, OP_XOR: bad = 1'b1;
        default: bad = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BIT_W = $clog2(NIB_W)
) (
  input  op_e              op,
  input  logic [NIB_W-1:0] nib,
  input  logic [BIT_W-1:0] bsel,
  input  logic             cy,
  output logic [NIB_W-1:0] wdata,
  output logic             wr,
  output logic             skip_req,
  output logic             cy_new
);
  logic [NIB_W-1:0] sel;
  logic             bval;
  logic             nbit;

  for (genvar i = 0; i < NIB_W; i++) begin : g_lane
    assign sel[i]   = (bsel == BIT_W'(i));
    assign wdata[i] = sel[i] ? nbit : nib[i];
  end

  assign bval = |(nib & sel);

  always_comb begin
    nbit     = 1'b0;
    wr       = 1'b0;
    skip_req = 1'b0;
    cy_new   = cy;
    unique case (op)
      OP_SET:    begin nbit = 1'b1; wr = 1'b1; end
      OP_CLR:    begin nbit = 1'b0; wr = 1'b1; end
      OP_SKT:    skip_req = bval;
      OP_SKF:    skip_req = ~bval;
      OP_SKTCLR: begin nbit = 1'b0; wr = bval; skip_req = bval; end
      OP_AND:    cy_new = cy & bval;
      OP_OR:     cy_new = cy | bval;
      OP_XOR:    cy_new = cy ^ bval;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bad,
  output logic ready,
  output logic rd_phase,
  output logic ex_phase,
  output logic ill_phase
);
  state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = bad ? ST_ILL : ST_READ;
      ST_READ: st_d = ST_EXEC;
      ST_EXEC: st_d = ST_IDLE;
      ST_ILL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign ready     = (st_q == ST_IDLE);
  assign rd_phase  = (st_q == ST_READ);
  assign ex_phase  = (st_q == ST_EXEC);
  assign ill_phase = (st_q == ST_ILL);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NIB_W     = 4,
  parameter int WIN_OFS_W = 6,
  parameter logic [ADDR_W-1:0] WIN_BASE = 8'hC0,
  localparam int BIT_W    = $clog2(NIB_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_mode,
  input  logic [ADDR_W-1:0] in_imm,
  input  logic [BIT_W-1:0]  in_bit,
  input  logic [NIB_W-1:0]  in_h,
  input  logic [NIB_W-1:0]  in_l,
  input  logic              in_cy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [NIB_W-1:0]  mem_rdata,
  output logic              mem_wr_en,
  output logic [NIB_W-1:0]  mem_wdata,
  output logic              done,
  output logic              skip,
  output logic              cy_out,
  output logic              illegal
);
  op_e               op_in;
  mode_e             mode_in;
  logic [ADDR_W-1:0] addr_c;
  logic [BIT_W-1:0]  bsel_c;
  logic              bad_c;
  logic              start;
  logic              rd_ph, ex_ph, ill_ph;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bsel_q;
  logic              cy_q;

  logic              alu_wr, alu_skip, alu_cy;
  logic [NIB_W-1:0]  alu_wdata;

  assign op_in   = op_e'(in_op);
  assign mode_in = mode_e'(in_mode);
  assign start   = in_valid & in_ready;

  bitop_addr_gen #(
    .ADDR_W(ADDR_W), .NIB_W(NIB_W), .WIN_OFS_W(WIN_OFS_W), .WIN_BASE(WIN_BASE)
  ) u_agen (
    .op(op_in), .mode(mode_in), .imm(in_imm), .bit_imm(in_bit),
    .h(in_h), .l(in_l), .addr(addr_c), .bsel(bsel_c), .bad(bad_c)
  );

  bitop_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bad(bad_c),
    .ready(in_ready), .rd_phase(rd_ph), .ex_phase(ex_ph), .ill_phase(ill_ph)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_SKT;
      addr_q <= '0;
      bsel_q <= '0;
      cy_q   <= 1'b0;
    end else if (start) begin
      op_q   <= op_in;
      addr_q <= addr_c;
      bsel_q <= bsel_c;
      cy_q   <= in_cy;
    end
  end

  bitop_alu #(.NIB_W(NIB_W)) u_alu (
    .op(op_q), .nib(mem_rdata), .bsel(bsel_q), .cy(cy_q),
    .wdata(alu_wdata), .wr(alu_wr), .skip_req(alu_skip), .cy_new(alu_cy)
  );

  assign mem_addr  = addr_q;
  assign mem_rd_en = rd_ph;
  assign mem_wr_en = ex_ph & alu_wr;
  assign mem_wdata = alu_wdata;
  assign done      = ex_ph | ill_ph;
  assign skip      = ex_ph & alu_skip;
  assign cy_out    = ex_ph ? alu_cy : cy_q;
  assign illegal   = ill_ph;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              done,
  input logic              skip,
  input logic              illegal
);
  a_r11_skip_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done);

  a_r11_illegal_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_rd_en && !mem_wr_en && !skip));

  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && mem_addr == $past(mem_addr)));

  a_r9_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (done && !illegal));

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || done) |-> !in_ready);
endmodule

bind bitop_unit bitop_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_addr(mem_addr),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .done(done),
  .skip(skip), .illegal(illegal)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SET = 3'd0, CLR = 3'd1, SKT = 3'd2, SKF = 3'd3,
                         SKC = 3'd4, ANDC = 3'd5, ORC = 3'd6, XORC = 3'd7;
  localparam logic [1:0] DIR = 2'd0, WIN = 2'd1, RIX = 2'd2, HPG = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [1:0] in_mode = '0;
  logic [7:0] in_imm = '0;
  logic [1:0] in_bit = '0;
  logic [3:0] in_h = '0, in_l = '0;
  logic       in_cy = 1'b0;
  logic [7:0] mem_addr;
  logic       mem_rd_en, mem_wr_en;
  logic [3:0] mem_rdata = '0, mem_wdata;
  logic       done, skip, cy_out, illegal;

  logic [3:0] mem [256];
  int checks = 0, failures = 0;
  bit finished = 0;

  int   g_lat;
  bit   g_seen_rd;
  logic [7:0] g_rd_addr;
  logic g_skip, g_cy, g_ill;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  bitop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode), .in_imm(in_imm), .in_bit(in_bit),
    .in_h(in_h), .in_l(in_l), .in_cy(in_cy), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .done(done), .skip(skip), .cy_out(cy_out),
    .illegal(illegal)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] mode,
                       input logic [7:0] imm, input logic [1:0] b,
                       input logic [3:0] h, input logic [3:0] l, input logic cy);
    @(negedge clk);
    in_op = op; in_mode = mode; in_imm = imm; in_bit = b;
    in_h = h; in_l = l; in_cy = cy; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    g_lat = 1; g_seen_rd = 0; g_rd_addr = '0;
    while (!done && g_lat < 8) begin
      if (mem_rd_en) begin g_seen_rd = 1; g_rd_addr = mem_addr; end
      @(negedge clk);
      g_lat++;
    end
    g_skip = skip; g_cy = cy_out; g_ill = illegal;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready after reset", int'(in_ready), 1);
    chk("R11 done low after reset", int'(done), 0);
    chk("R11 skip low after reset", int'(skip), 0);
  endtask

  task automatic t_set_clr_direct();
    mem[8'h25] = 4'b0000;
    issue(SET, DIR, 8'h25, 2'd2, 4'h0, 4'h0, 1'b0);
    chk("R2 direct address", int'(g_rd_addr), 8'h25);
    chk("R9 legal latency", g_lat, 2);
    chk("R5 set bit2", int'(mem[8'h25]), 4'b0100);
    chk("R8 cy passes through set", int'(g_cy), 0);
    mem[8'h31] = 4'b1111;
    issue(CLR, DIR, 8'h31, 2'd0, 4'h0, 4'h0, 1'b1);
    chk("R5 clear bit0", int'(mem[8'h31]), 4'b1110);
    chk("R8 cy passes through clear", int'(g_cy), 1);
    chk("R1 ready again", int'(in_ready), 1);
  endtask

  task automatic t_window();
    mem[8'hFA] = 4'b0000;
    issue(SET, WIN, 8'h3A, 2'd3, 4'h0, 4'h0, 1'b0);
    chk("R2 window address", int'(g_rd_addr), 8'hFA);
    chk("R5 window set bit3", int'(mem[8'hFA]), 4'b1000);
    mem[8'hC5] = 4'b0110;
    issue(SKT, WIN, 8'h85, 2'd1, 4'h0, 4'h0, 1'b0);
    chk("R2 window ignores imm high bits", int'(g_rd_addr), 8'hC5);
    chk("R6 skip-if-one on 1", int'(g_skip), 1);
  endtask

  task automatic t_regidx();
    mem[8'h5B] = 4'b0100;
    issue(SKT, RIX, 8'h58, 2'd0, 4'h0, 4'b1110, 1'b0);
    chk("R3 register-indexed address", int'(g_rd_addr), 8'h5B);
    chk("R3 bit index from L, skip", int'(g_skip), 1);
    chk("R6 no write on test", int'(mem[8'h5B]), 4'b0100);
    mem[8'h5B] = 4'b1011;
    issue(SKT, RIX, 8'h58, 2'd3, 4'h0, 4'b1110, 1'b0);
    chk("R3 in_bit ignored, no skip", int'(g_skip), 0);
  endtask

  task automatic t_hpage();
    mem[8'hA7] = 4'b0000;
    issue(SKF, HPG, 8'h37, 2'd1, 4'hA, 4'h0, 1'b0);
    chk("R4 H-paged address", int'(g_rd_addr), 8'hA7);
    chk("R6 skip-if-zero on 0", int'(g_skip), 1);
    mem[8'hA7] = 4'b0010;
    issue(SKF, HPG, 8'h37, 2'd1, 4'hA, 4'h0, 1'b0);
    chk("R6 skip-if-zero on 1", int'(g_skip), 0);
    mem[8'h12] = 4'b1111;
    issue(SKT, DIR, 8'h12, 2'd3, 4'h0, 4'h0, 1'b0);
    chk("R6 direct skip-if-one", int'(g_skip), 1);
  endtask

  task automatic t_test_clear();
    mem[8'h9D] = 4'b1010;
    issue(SKC, RIX, 8'h9C, 2'd0, 4'h0, 4'b0101, 1'b0);
    chk("R7 skip when set", int'(g_skip), 1);
    chk("R7 bit cleared", int'(mem[8'h9D]), 4'b1000);
    issue(SKC, RIX, 8'h9C, 2'd0, 4'h0, 4'b0101, 1'b0);
    chk("R7 no skip when clear", int'(g_skip), 0);
    chk("R7 nibble unchanged", int'(mem[8'h9D]), 4'b1000);
  endtask

  task automatic t_carry();
    mem[8'h64] = 4'b1000;
    issue(ANDC, HPG, 8'h04, 2'd3, 4'h6, 4'h0, 1'b0);
    chk("R8 and 0&1", int'(g_cy), 0);
    issue(ORC, HPG, 8'h04, 2'd3, 4'h6, 4'h0, 1'b0);
    chk("R8 or 0|1", int'(g_cy), 1);
    issue(XORC, HPG, 8'h04, 2'd3, 4'h6, 4'h0, 1'b1);
    chk("R8 xor 1^1", int'(g_cy), 0);
    issue(ANDC, WIN, 8'h24, 2'd0, 4'h0, 4'h0, 1'b1);
    chk("R8 and 1&0", int'(g_cy), 0);
    issue(XORC, HPG, 8'h04, 2'd0, 4'h6, 4'h0, 1'b1);
    chk("R8 xor 1^0", int'(g_cy), 1);
    chk("R8 memory untouched", int'(mem[8'h64]), 4'b1000);
    chk("R8 no skip", int'(g_skip), 0);
  endtask

  task automatic t_illegal();
    mem[8'h40] = 4'b1111;
    issue(SKC, DIR, 8'h40, 2'd1, 4'h0, 4'h0, 1'b1);
    chk("R10 illegal flag", int'(g_ill), 1);
    chk("R10 illegal latency", g_lat, 1);
    chk("R10 no read", int'(g_seen_rd), 0);
    chk("R10 no skip", int'(g_skip), 0);
    chk("R10 cy kept", int'(g_cy), 1);
    chk("R10 memory kept", int'(mem[8'h40]), 4'b1111);
    issue(ORC, DIR, 8'h40, 2'd1, 4'h0, 4'h0, 1'b0);
    chk("R10 carry op illegal in direct", int'(g_ill), 1);
    chk("R10 cy kept low", int'(g_cy), 0);
    issue(SET, DIR, 8'h40, 2'd1, 4'h0, 4'h0, 1'b0);
    chk("R10 set legal in direct", int'(g_ill), 0);
    chk("R11 illegal low after", int'(illegal), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'(i) ^ 4'(i >> 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clr_direct();
    t_window();
    t_regidx();
    t_hpage();
    t_test_clear();
    t_carry();
    t_illegal();
    summary();
    $finish;
  end
endmodule